// File: doc/BRIEF.md
# Left/Center Aligned PWM Channel

This block produces one pulse-width-modulated output. Its counter advances on a selectable tick. The tick is the core clock divided by a power of two from 1 to 1024, or one of two externally supplied divider ticks. The waveform is set by four values: a period, a duty, a start level and an alignment mode. In left-aligned mode the counter ramps up and wraps. In center-aligned mode it climbs to the period value and falls back to zero, which doubles the period and places the active part of the pulse symmetrically about the middle of the period. Two channels with suitable duties therefore give pulses that never overlap.

The four settings are shadowed. A value written mid-period takes effect only when the period ends, so the output never glitches. While the channel is disabled, the shadow follows the inputs directly. A one-clock end-of-period strobe marks the first clock cycle of every new period. It lets a controller pace its updates.

Top module: `pwm_channel`

## Requirements
- R1: After reset the output is low, the end-of-period strobe is low, and the shadowed settings are period 1, duty 0, start level low and left alignment.
- R2: The 4-bit clock select picks the counter tick. Codes 0 to 10 select the core clock divided by 2 to the power of the code. The prescaler is a free-running counter cleared by reset, and division by 2^k ticks when its k low bits are all ones. Code 11 selects auxiliary tick A, code 12 selects auxiliary tick B, and codes 13 to 15 hold the counter.
- R3: With the alignment input at 0 (left), the counter takes the values 0 to P-1 and then wraps, so a period lasts P ticks. The output sits at the start level while the count is below P-D and at the opposite level otherwise.
- R4: With the alignment input at 1 (center), the counter rises from 0 to P and then falls back to 0, so a period lasts 2P ticks. On the way up the output is at the opposite level when the count is at least P-D. On the way down it is at the opposite level when the count exceeds P-D.
- R5: A start-level input of 0 makes each period start low; a 1 makes it start high.
- R6: A duty of 0 keeps the output at the start level for the whole period. A duty equal to or larger than the period keeps it at the opposite level for the whole period.
- R7: The end-of-period strobe is high for one clock cycle: the cycle in which the counter has just wrapped to 0 (left) or has just returned to 0 (center).
- R8: Period, duty, start level and alignment are taken into use only on the clock edge that ends a period, or on any edge while the channel is disabled.
- R9: While the channel is disabled, the counter is held at 0, the strobe stays low, and from the next edge on the output is at the start level.
- R10: A period value of 0 behaves exactly as a period value of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable |
| clk_sel | input | 4 | Tick source select code |
| aux_tick_a | input | 1 | Auxiliary divider tick A, one clock wide |
| aux_tick_b | input | 1 | Auxiliary divider tick B, one clock wide |
| period | input | 16 | Period value P |
| duty | input | 16 | Duty value D |
| start_high | input | 1 | Start level of each period (1 = high) |
| center_mode | input | 1 | Alignment (0 = left, 1 = center) |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | End-of-period strobe |

## Verification
Both outputs are decoded from registers only. A tick seen on one clock edge therefore moves the counter on that edge and shows on `pwm_out` and `period_end` one cycle later. A setting change or an enable change takes effect at the next period-ending edge or the next edge. The bench drives every input just after a falling edge. In that same half cycle it compares the outputs with a reference model, then advances the model by one edge using the inputs just applied, so each result is checked in exactly the cycle it is due.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the PWM channel.
// Assumes: codes below the prescaler stage count select prescaler taps.
package pwm_pkg;

    // Alignment mode carried by the shadow register
    typedef enum logic {
        ALIGN_LEFT   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;

    // Number of power-of-two prescaler outputs (divide by 1 .. 1024)
    localparam int PWM_PRE_STAGES = 11;

    // Width of the tick select code
    localparam int PWM_SEL_W = 4;

endpackage

// File: rtl/pwm_tick_sel.sv
`timescale 1ns/1ps
// Tick source for the channel counter.
// Free-running prescaler: tap k fires once every 2^k clocks.
// The select code then picks a tap, an auxiliary tick, or nothing.
// Assumes the auxiliary ticks are already one clock wide and synchronous.
module pwm_tick_sel #(
    parameter int PRE_STAGES = pwm_pkg::PWM_PRE_STAGES,
    parameter int SEL_W      = pwm_pkg::PWM_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             aux_a,
    input  logic             aux_b,
    output logic             tick
);

    localparam int PRE_W = (PRE_STAGES > 1) ? PRE_STAGES - 1 : 1;
    localparam logic [SEL_W-1:0] CODE_AUX_A = SEL_W'(PRE_STAGES);
    localparam logic [SEL_W-1:0] CODE_AUX_B = SEL_W'(PRE_STAGES + 1);

    logic [PRE_W-1:0]      pre_cnt;
    logic [PRE_STAGES-1:0] taps;

    // Free-running prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Divide-by-2^k strobes decoded from the low bits of the prescaler
    generate
        for (genvar k = 0; k < PRE_STAGES; k++) begin : g_tap
            if (k == 0) begin : g_div1
                assign taps[k] = 1'b1;
            end else begin : g_divn
                assign taps[k] = &pre_cnt[k-1:0];
            end
        end
    endgenerate

    // Select one tick source from the code
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < PRE_STAGES; k++) begin
            if (sel == SEL_W'(k)) begin
                tick = taps[k];
            end
        end
        if (sel == CODE_AUX_A) begin
            tick = aux_a;
        end
        if (sel == CODE_AUX_B) begin
            tick = aux_b;
        end
    end

endmodule

// File: rtl/pwm_shadow.sv
`timescale 1ns/1ps
// Shadow copy of the waveform settings.
// Loads on request only, so the active values stay constant within a period.
// Stores a sanitized form: period at least 1, duty at most the period.
module pwm_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] prd_i,
    input  logic [CNT_W-1:0] dty_i,
    input  logic             pol_i,
    input  logic             ctr_i,
    output logic [CNT_W-1:0] prd_q,
    output logic [CNT_W-1:0] dty_q,
    output logic             pol_q,
    output pwm_pkg::align_e  ctr_q
);

    logic [CNT_W-1:0] prd_fix;
    logic [CNT_W-1:0] dty_fix;

    // Sanitize incoming values before they are stored
    always_comb begin
        prd_fix = (prd_i == '0) ? CNT_W'(1) : prd_i;
        dty_fix = (dty_i > prd_fix) ? prd_fix : dty_i;
    end

    // Capture the settings at a period boundary or while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q <= CNT_W'(1);
            dty_q <= '0;
            pol_q <= 1'b0;
            ctr_q <= pwm_pkg::ALIGN_LEFT;
        end else if (load) begin
            prd_q <= prd_fix;
            dty_q <= dty_fix;
            pol_q <= pol_i;
            ctr_q <= ctr_i ? pwm_pkg::ALIGN_CENTER : pwm_pkg::ALIGN_LEFT;
        end
    end

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
// Period counter with left (wrap) and center (up/down) modes.
// Left: 0..prd-1 then wrap. Center: up 0..prd, down to 0.
// Assumes prd >= 1 (guaranteed by the shadow register).
// wrap is combinational and marks the edge that ends a period.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd,
    input  pwm_pkg::align_e  ctr,
    output logic [CNT_W-1:0] cnt,
    output logic             up,
    output logic             run,
    output logic             wrap,
    output logic             eop
);

    logic [CNT_W:0] cnt_inc;
    logic           end_hit;

    // Detect the last tick of the current period
    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        if (ctr == pwm_pkg::ALIGN_CENTER) begin
            end_hit = !up && (cnt == CNT_W'(1));
        end else begin
            end_hit = (cnt >= prd - 1'b1);
        end
        wrap = en && tick && end_hit;
    end

    // Advance the count and the direction, and register the end strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b1;
            run <= 1'b0;
            eop <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            up  <= 1'b1;
            run <= 1'b0;
            eop <= 1'b0;
        end else begin
            run <= 1'b1;
            eop <= wrap;
            if (tick) begin
                if (wrap) begin
                    cnt <= '0;
                    up  <= 1'b1;
                end else if (ctr == pwm_pkg::ALIGN_CENTER) begin
                    if (up) begin
                        cnt <= cnt_inc[CNT_W-1:0];
                        if (cnt_inc >= {1'b0, prd}) begin
                            up <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    cnt <= cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/pwm_compare.sv
`timescale 1ns/1ps
// Output level decode from counter state and active settings.
// The active part of the period sits at the top of the count range, so
// center mode gives a pulse symmetric about the period midpoint.
// Purely combinational; every input comes from a register.
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic             run,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] dty,
    input  logic             pol,
    input  pwm_pkg::align_e  ctr,
    output logic             out
);

    logic [CNT_W-1:0] edge_pt;
    logic             opp;

    // Choose start or opposite level for the current count
    always_comb begin
        edge_pt = prd - dty;
        if (ctr == pwm_pkg::ALIGN_CENTER && !up) begin
            opp = (cnt > edge_pt);
        end else begin
            opp = (cnt >= edge_pt);
        end
        out = pol ^ (run && opp);
    end

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// Single PWM channel: tick select, settings shadow, counter, output decode.
// Settings are taken into use at period ends, or at any edge while disabled.
// Both outputs come from registers, so they lag their cause by one clock.
module pwm_channel #(
    parameter int CNT_W      = 16,
    parameter int PRE_STAGES = pwm_pkg::PWM_PRE_STAGES,
    parameter int SEL_W      = pwm_pkg::PWM_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             aux_tick_a,
    input  logic             aux_tick_b,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             start_high,
    input  logic             center_mode,
    output logic             pwm_out,
    output logic             period_end
);

    logic             tick;
    logic             load;
    logic [CNT_W-1:0] prd_q;
    logic [CNT_W-1:0] dty_q;
    logic             pol_q;
    pwm_pkg::align_e  ctr_q;
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             run;
    logic             wrap;

    // Shadow load at period end, or continuously while disabled
    assign load = !en || wrap;

    pwm_tick_sel #(
        .PRE_STAGES (PRE_STAGES),
        .SEL_W      (SEL_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .aux_a (aux_tick_a),
        .aux_b (aux_tick_b),
        .tick  (tick)
    );

    pwm_shadow #(
        .CNT_W (CNT_W)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .prd_i (period),
        .dty_i (duty),
        .pol_i (start_high),
        .ctr_i (center_mode),
        .prd_q (prd_q),
        .dty_q (dty_q),
        .pol_q (pol_q),
        .ctr_q (ctr_q)
    );

    pwm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .prd   (prd_q),
        .ctr   (ctr_q),
        .cnt   (cnt),
        .up    (up),
        .run   (run),
        .wrap  (wrap),
        .eop   (period_end)
    );

    pwm_compare #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .cnt (cnt),
        .up  (up),
        .run (run),
        .prd (prd_q),
        .dty (dty_q),
        .pol (pol_q),
        .ctr (ctr_q),
        .out (pwm_out)
    );

endmodule

// File: rtl/pwm_channel_chk.sv
`timescale 1ns/1ps
// Property checker for pwm_channel, attached by bind below.
// Observes internal state of the channel alongside its ports.
module pwm_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic [CNT_W-1:0] prd_q,
    input logic [CNT_W-1:0] dty_q,
    input logic             pol_q,
    input logic             ctr_q,
    input logic             pwm_out,
    input logic             period_end
);

    // R7: the strobe only appears with a running counter sitting at zero
    p_eop_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (cnt == '0) && run);

    // R2: without a tick the count does not move
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt));

    // R3: left alignment keeps the count below the period
    p_left_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctr_q |-> (cnt < prd_q));

    // R4: center alignment never passes the period value
    p_center_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q |-> (cnt <= prd_q));

    // R6: stored duty never exceeds stored period
    p_duty_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dty_q <= prd_q);

    // R8: settings stay frozen inside a running period
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> $stable(prd_q) && $stable(dty_q)
                          && $stable(pol_q) && $stable(ctr_q));

    // R9: an idle channel rests at its start level with no strobe
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == pol_q) && !period_end);

endmodule

bind pwm_channel pwm_channel_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick),
    .wrap       (wrap),
    .cnt        (cnt),
    .run        (run),
    .prd_q      (prd_q),
    .dty_q      (dty_q),
    .pol_q      (pol_q),
    .ctr_q      (ctr_q),
    .pwm_out    (pwm_out),
    .period_end (period_end)
);

// File: tb/pwm_channel_bench.sv
`timescale 1ns/1ps
// Self-checking bench: cycle-accurate reference model driven by
// directed corner cases and seeded random stimulus.
module pwm_channel_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [3:0]    clk_sel;
    logic          aux_tick_a;
    logic          aux_tick_b;
    logic [CW-1:0] period;
    logic [CW-1:0] duty;
    logic          start_high;
    logic          center_mode;
    logic          pwm_out;
    logic          period_end;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R1";

    // Reference model state
    int m_pre, m_cnt, m_prd, m_dty;
    bit m_up, m_eop, m_run, m_pol, m_ctr;

    always #10 clk = ~clk;

    pwm_channel u_pwm_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .clk_sel     (clk_sel),
        .aux_tick_a  (aux_tick_a),
        .aux_tick_b  (aux_tick_b),
        .period      (period),
        .duty        (duty),
        .start_high  (start_high),
        .center_mode (center_mode),
        .pwm_out     (pwm_out),
        .period_end  (period_end)
    );

    function automatic bit model_tick();
        int k = int'(clk_sel);
        int msk;
        if (k <= 10) begin
            msk = (1 << k) - 1;
            return (m_pre & msk) == msk;
        end
        if (k == 11) return aux_tick_a;
        if (k == 12) return aux_tick_b;
        return 1'b0;
    endfunction

    function automatic bit model_out();
        int  pt  = m_prd - m_dty;
        bit  opp = (m_ctr && !m_up) ? (m_cnt > pt) : (m_cnt >= pt);
        return m_pol ^ (m_run && opp);
    endfunction

    task automatic model_load();
        m_prd = (int'(period) == 0) ? 1 : int'(period);
        m_dty = (int'(duty) > m_prd) ? m_prd : int'(duty);
        m_pol = start_high;
        m_ctr = center_mode;
    endtask

    task automatic model_reset();
        m_pre = 0; m_cnt = 0; m_up = 1; m_eop = 0; m_run = 0;
        m_prd = 1; m_dty = 0; m_pol = 0; m_ctr = 0;
    endtask

    task automatic model_edge();
        bit t, w;
        if (!rst_n) begin
            model_reset();
            return;
        end
        t = model_tick();
        m_pre = (m_pre + 1) % 1024;
        if (!en) begin
            m_cnt = 0; m_up = 1; m_eop = 0; m_run = 0;
            model_load();
            return;
        end
        m_run = 1;
        w = t && (m_ctr ? (!m_up && m_cnt == 1) : (m_cnt >= m_prd - 1));
        m_eop = w;
        if (t) begin
            if (w) begin
                m_cnt = 0; m_up = 1;
            end else if (m_ctr) begin
                if (m_up) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt >= m_prd) m_up = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (w) model_load();
    endtask

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: compare outputs, advance the model, move to next falling edge
    task automatic step();
        aux_tick_a = ($urandom % 3) == 0;
        aux_tick_b = ($urandom % 5) == 0;
        check({tag, " pwm_out"}, int'(pwm_out), int'(model_out()));
        check({"R7 ", tag, " period_end"}, int'(period_end), int'(m_eop));
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup(int s, int p, int d, bit pol, bit ctr);
        clk_sel = 4'(s); period = CW'(p); duty = CW'(d);
        start_high = pol; center_mode = ctr;
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; en = 1'b0;
        aux_tick_a = 1'b0; aux_tick_b = 1'b0;
        setup(0, 5, 2, 1'b0, 1'b0);
        model_reset();
        @(negedge clk);
        // R1: outputs low and idle throughout reset
        tag = "R1";
        run_n(4);
        rst_n = 1'b1;
        check("R1 pwm_out after reset", int'(pwm_out), 0);
        check("R1 period_end after reset", int'(period_end), 0);
        run_n(3);

        // R3: left aligned, divide by 1
        tag = "R3"; en = 1'b1;
        run_n(40);
        setup(1, 7, 3, 1'b0, 1'b0);
        run_n(60);

        // R5: start level high
        tag = "R5";
        setup(0, 6, 2, 1'b1, 1'b0);
        run_n(40);
        setup(0, 5, 3, 1'b1, 1'b1);
        run_n(40);

        // R4: center aligned up/down
        tag = "R4";
        setup(0, 4, 1, 1'b0, 1'b1);
        run_n(60);
        setup(2, 6, 4, 1'b0, 1'b1);
        run_n(150);

        // R6: duty extremes in both modes
        tag = "R6";
        setup(0, 6, 0, 1'b0, 1'b0);  run_n(30);
        setup(0, 6, 9, 1'b0, 1'b0);  run_n(30);
        setup(0, 6, 0, 1'b1, 1'b1);  run_n(40);
        setup(0, 6, 6, 1'b0, 1'b1);  run_n(40);

        // R10: period zero behaves like one
        tag = "R10";
        setup(0, 0, 0, 1'b0, 1'b0);  run_n(10);
        setup(0, 0, 1, 1'b0, 1'b1);  run_n(12);
        setup(0, 1, 1, 1'b1, 1'b0);  run_n(10);

        // R2: every select code, including aux ticks and hold codes
        tag = "R2";
        for (int c = 0; c < 16; c++) begin
            setup(c, 3, 1, 1'b0, c[0]);
            run_n(c >= 8 && c <= 10 ? 2600 : 200);
        end

        // R9: disable mid-period, change settings while idle, re-enable
        tag = "R9";
        setup(0, 8, 3, 1'b0, 1'b0);
        run_n(13);
        en = 1'b0; run_n(3);
        setup(0, 5, 2, 1'b1, 1'b1); run_n(4);
        en = 1'b1; run_n(30);

        // R8: settings change every few cycles, mid-period
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            if ((i % 7) == 3) setup(i % 3, 2 + (i % 9), i % 11, i[3], i[4]);
            step();
        end

        // R3/R4 random mix with occasional disables
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 25) == 0) begin
                int s;
                s = (($urandom % 4) == 0) ? int'($urandom % 16) : int'($urandom % 3);
                setup(s, int'($urandom % 13), int'($urandom % 15),
                      1'($urandom), 1'($urandom));
            end
            if (($urandom % 150) == 0) en = ~en;
            tag = m_ctr ? "R4 rnd" : "R3 rnd";
            if (!en) tag = "R9 rnd";
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule